// File: doc/BRIEF.md
# Indexed stream link read unit

This execute-stage unit carries out a processor instruction that pulls one word from one of up to sixteen AXI4-Stream slave links. The link is chosen at run time from the low four bits of an index operand. Flag inputs pick the non-blocking form, the expected end-of-packet marker, and whether a marker mismatch should trap. A user-mode input lets the unit refuse the access when software in user mode may not touch the links.

The pipeline presents the request as a one-cycle strobe. The unit then holds its stall output high until the instruction finishes. It finishes with exactly one pulse: either a done pulse, which carries the destination data and an optional carry update, or an exception pulse, which carries an exception code, a syndrome and a data word. A status bit records marker mismatches. That bit stays set until reset. Parameters set the number of links, whether stream exceptions exist at all, whether user mode may access the links, and whether an extra setup cycle is inserted to shorten the logic paths.

Top module: `strm_link_rd`

## Requirements
- R1: The link number is the value of `idx_i[3:0]` (bit 0 is the least significant bit). When that value is greater than or equal to `NUM_LINKS`, link 0 is used instead. The other index bits have no effect.
- R2: A completed transfer pulses `done_o` and `rd_we_o` together, with `rd_data_o` equal to the TDATA that the selected link presented in the consuming cycle.
- R3: `s_tready_o` is high for at most one link. It is high only on the selected link, only while that link's TVALID is high, and only in the single cycle in which the word is taken.
- R4: In the blocking form (`nonblk_i`=0), the unit keeps `stall_o` high and does not complete for as long as the selected link's TVALID is low.
- R5: In the non-blocking form, the instruction completes without waiting. It pulses `carry_we_o` with `carry_o` equal to the inverse of the selected link's TVALID. The blocking form never pulses `carry_we_o`.
- R6: When the selected link is valid and its TLAST differs from `ctrl_i`, `serr_o` becomes 1. Only reset clears it.
- R7: On such a mismatch, when `exc_en_i`=1 and the parameter `EXC_EN`=1, the unit pulses `exc_o` instead of `done_o`. It sets `exc_code_o`=5'b00000, `exc_syn_o` to the link number and `exc_data_o` to the word, and it does not pulse `rd_we_o`. With `EXC_EN`=0, `exc_en_i` has no effect.
- R8: When `user_mode_i`=1 and `ALLOW_USER`=0, the unit pulses `exc_o` with `exc_code_o`=5'b00111. It raises no TREADY, and it pulses neither `rd_we_o` nor `carry_we_o`.
- R9: A request whose link already holds data completes with its pulse visible two cycles after the request strobe when `AREA_OPT`=0, and three cycles after it when `AREA_OPT`=1.
- R10: Every accepted request yields exactly one pulse of `done_o` or `exc_o`, never both at once. A `req_i` that arrives while `stall_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken only while idle |
| idx_i | input | IDX_W | Index operand; the low four bits pick the link |
| nonblk_i | input | 1 | 1 = non-blocking form |
| ctrl_i | input | 1 | Expected TLAST value |
| exc_en_i | input | 1 | Trap on marker mismatch |
| user_mode_i | input | 1 | Processor is in user mode |
| s_tvalid_i | input | NUM_LINKS | TVALID per link |
| s_tlast_i | input | NUM_LINKS | TLAST per link |
| s_tdata_i | input | NUM_LINKS*DATA_W | TDATA per link, link i at bits [i*DATA_W +: DATA_W] |
| s_tready_o | output | NUM_LINKS | TREADY per link |
| stall_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Normal completion pulse |
| rd_we_o | output | 1 | Destination write pulse |
| rd_data_o | output | DATA_W | Destination value |
| carry_we_o | output | 1 | Carry update pulse |
| carry_o | output | 1 | New carry value |
| serr_o | output | 1 | Sticky marker-mismatch status |
| exc_o | output | 1 | Exception pulse |
| exc_code_o | output | 5 | Exception code |
| exc_syn_o | output | 4 | Syndrome: link number of a stream exception |
| exc_data_o | output | DATA_W | Word that caused a stream exception |

## Verification
The assertions assume that each link's TVALID is a level that stays steady between clock edges, so that the check tying TREADY to TVALID compares values that belong to the same cycle. They also assume that only reset can lower the status bit. The bench changes link inputs, flags and the request strobe only just after the falling edge. It drives both instances from one shared set of links and never lets a link withdraw a word in the middle of a cycle. Because the bench never pops words, a link that stays valid is simply read again by the next request. Neither the assertions nor the reference model need any assumption about AXI4-Stream ordering across transfers.

// File: rtl/strm_rd_pkg.sv
package strm_rd_pkg;

    localparam int LINK_SEL_W = 4;
    localparam int EXC_CODE_W = 5;

    localparam logic [EXC_CODE_W-1:0] EC_STREAM = 5'b00000;
    localparam logic [EXC_CODE_W-1:0] EC_PRIV   = 5'b00111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ACT   = 2'd2
    } rd_state_e;

endpackage

// File: rtl/strm_rd_idx_clamp.sv
module strm_rd_idx_clamp
    import strm_rd_pkg::*;
#(
    parameter int NUM_LINKS = 4
) (
    input  logic [LINK_SEL_W-1:0] idx_lo_i,
    output logic [LINK_SEL_W-1:0] sel_o
);

    localparam logic [LINK_SEL_W:0] LIMIT = (LINK_SEL_W+1)'(NUM_LINKS);

    // out-of-range link numbers fall back to link 0
    assign sel_o = ({1'b0, idx_lo_i} >= LIMIT) ? '0 : idx_lo_i;

endmodule

// File: rtl/strm_rd_link_mux.sv
module strm_rd_link_mux
    import strm_rd_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int DATA_W    = 32
) (
    input  logic [LINK_SEL_W-1:0]       sel_i,
    input  logic                        grant_i,
    input  logic [NUM_LINKS-1:0]        tvalid_i,
    input  logic [NUM_LINKS-1:0]        tlast_i,
    input  logic [NUM_LINKS*DATA_W-1:0] tdata_i,
    output logic                        vld_o,
    output logic                        last_o,
    output logic [DATA_W-1:0]           data_o,
    output logic [NUM_LINKS-1:0]        tready_o
);

    logic [NUM_LINKS-1:0] hit;

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        assign hit[g]      = (sel_i == LINK_SEL_W'(g));
        assign tready_o[g] = grant_i & hit[g];
    end

    always_comb begin
        vld_o  = 1'b0;
        last_o = 1'b0;
        data_o = '0;
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (hit[i]) begin
                vld_o  = tvalid_i[i];
                last_o = tlast_i[i];
                data_o = tdata_i[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/strm_link_rd.sv
module strm_link_rd
    import strm_rd_pkg::*;
#(
    parameter int NUM_LINKS  = 4,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 32,
    parameter bit EXC_EN     = 1'b1,
    parameter bit ALLOW_USER = 1'b0,
    parameter bit AREA_OPT   = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic                        nonblk_i,
    input  logic                        ctrl_i,
    input  logic                        exc_en_i,
    input  logic                        user_mode_i,
    input  logic [NUM_LINKS-1:0]        s_tvalid_i,
    input  logic [NUM_LINKS-1:0]        s_tlast_i,
    input  logic [NUM_LINKS*DATA_W-1:0] s_tdata_i,
    output logic [NUM_LINKS-1:0]        s_tready_o,
    output logic                        stall_o,
    output logic                        done_o,
    output logic                        rd_we_o,
    output logic [DATA_W-1:0]           rd_data_o,
    output logic                        carry_we_o,
    output logic                        carry_o,
    output logic                        serr_o,
    output logic                        exc_o,
    output logic [EXC_CODE_W-1:0]       exc_code_o,
    output logic [LINK_SEL_W-1:0]       exc_syn_o,
    output logic [DATA_W-1:0]           exc_data_o
);

    typedef struct packed {
        rd_state_e               st;
        logic [LINK_SEL_W-1:0]   link;
        logic                    nb;
        logic                    ctrl;
        logic                    trap;
        logic                    priv;
        logic                    done;
        logic                    rd_we;
        logic [DATA_W-1:0]       rd_data;
        logic                    carry_we;
        logic                    carry;
        logic                    serr;
        logic                    exc;
        logic [EXC_CODE_W-1:0]   code;
        logic [LINK_SEL_W-1:0]   syn;
        logic [DATA_W-1:0]       edata;
    } rd_regs_t;

    rd_regs_t q, n;

    logic [LINK_SEL_W-1:0] sel_in;
    logic                  grant;
    logic                  lnk_vld;
    logic                  lnk_last;
    logic [DATA_W-1:0]     lnk_data;
    logic                  mismatch;
    rd_state_e             first_st;

    logic unused_idx_hi;
    assign unused_idx_hi = ^idx_i[IDX_W-1:LINK_SEL_W];

    // the area variant spends one extra cycle before touching the links
    if (AREA_OPT) begin : g_area
        assign first_st = ST_SETUP;
    end else begin : g_fast
        assign first_st = ST_ACT;
    end

    strm_rd_idx_clamp #(
        .NUM_LINKS (NUM_LINKS)
    ) u_clamp (
        .idx_lo_i (idx_i[LINK_SEL_W-1:0]),
        .sel_o    (sel_in)
    );

    strm_rd_link_mux #(
        .NUM_LINKS (NUM_LINKS),
        .DATA_W    (DATA_W)
    ) u_mux (
        .sel_i    (q.link),
        .grant_i  (grant),
        .tvalid_i (s_tvalid_i),
        .tlast_i  (s_tlast_i),
        .tdata_i  (s_tdata_i),
        .vld_o    (lnk_vld),
        .last_o   (lnk_last),
        .data_o   (lnk_data),
        .tready_o (s_tready_o)
    );

    assign mismatch = lnk_last ^ q.ctrl;

    always_comb begin
        n          = q;
        n.done     = 1'b0;
        n.rd_we    = 1'b0;
        n.carry_we = 1'b0;
        n.exc      = 1'b0;
        grant      = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    n.st   = first_st;
                    n.link = sel_in;
                    n.nb   = nonblk_i;
                    n.ctrl = ctrl_i;
                    n.trap = exc_en_i & EXC_EN;
                    n.priv = user_mode_i & ~ALLOW_USER;
                end
            end
            ST_SETUP: begin
                n.st = ST_ACT;
            end
            ST_ACT: begin
                if (q.priv) begin
                    n.exc  = 1'b1;
                    n.code = EC_PRIV;
                    n.st   = ST_IDLE;
                end else if (lnk_vld) begin
                    grant = 1'b1;
                    if (mismatch) begin
                        n.serr = 1'b1;
                    end
                    if (mismatch && q.trap) begin
                        n.exc   = 1'b1;
                        n.code  = EC_STREAM;
                        n.syn   = q.link;
                        n.edata = lnk_data;
                    end else begin
                        n.done    = 1'b1;
                        n.rd_we   = 1'b1;
                        n.rd_data = lnk_data;
                    end
                    if (q.nb) begin
                        n.carry_we = 1'b1;
                        n.carry    = 1'b0;
                    end
                    n.st = ST_IDLE;
                end else if (q.nb) begin
                    n.done     = 1'b1;
                    n.carry_we = 1'b1;
                    n.carry    = 1'b1;
                    n.st       = ST_IDLE;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign stall_o    = (q.st != ST_IDLE);
    assign done_o     = q.done;
    assign rd_we_o    = q.rd_we;
    assign rd_data_o  = q.rd_data;
    assign carry_we_o = q.carry_we;
    assign carry_o    = q.carry;
    assign serr_o     = q.serr;
    assign exc_o      = q.exc;
    assign exc_code_o = q.code;
    assign exc_syn_o  = q.syn;
    assign exc_data_o = q.edata;

endmodule

// File: rtl/strm_link_rd_chk.sv
module strm_link_rd_chk
    import strm_rd_pkg::*;
#(
    parameter int NUM_LINKS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_LINKS-1:0]  s_tvalid_i,
    input logic [NUM_LINKS-1:0]  s_tready_o,
    input logic                  stall_o,
    input logic                  done_o,
    input logic                  rd_we_o,
    input logic                  carry_we_o,
    input logic                  serr_o,
    input logic                  exc_o,
    input logic [EXC_CODE_W-1:0] exc_code_o
);

    // R3
    tready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_tready_o));

    // R3
    tready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tready_o & ~s_tvalid_i) == '0);

    // R3
    tready_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tready_o != '0) |-> stall_o);

    // R10
    done_exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && exc_o));

    // R10
    finish_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || exc_o) |-> $past(stall_o));

    // R6
    serr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |=> serr_o);

    // R8
    priv_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_o && exc_code_o == EC_PRIV) |-> (!rd_we_o && !carry_we_o));

    // R7
    strm_exc_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_o && exc_code_o == EC_STREAM) |-> !rd_we_o);

    // R2
    write_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> done_o);

endmodule

bind strm_link_rd strm_link_rd_chk #(
    .NUM_LINKS (NUM_LINKS)
) u_chk (.*);

// File: tb/tb_strm_link_rd.sv
module tb_rd_model #(
    parameter int NUM_LINKS = 5,
    parameter int DATA_W    = 32,
    parameter int EXC_EN    = 1,
    parameter int AREA_OPT  = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [31:0]                 idx,
    input  logic                        nb,
    input  logic                        ctrl,
    input  logic                        ee,
    input  logic                        um,
    input  logic [NUM_LINKS-1:0]        tvalid,
    input  logic [NUM_LINKS-1:0]        tlast,
    input  logic [NUM_LINKS*DATA_W-1:0] tdata,
    output logic                        e_done,
    output logic                        e_exc,
    output logic [4:0]                  e_code,
    output logic [3:0]                  e_syn,
    output logic [DATA_W-1:0]           e_data,
    output logic                        e_rdwe,
    output logic [DATA_W-1:0]           e_rdd,
    output logic                        e_cwe,
    output logic                        e_carry,
    output logic                        e_serr,
    output logic                        e_stall,
    output logic [NUM_LINKS-1:0]        e_tready
);
    int busy = 0;
    int wait_n = 0;
    int lk = 0;
    bit l_nb, l_ctrl, l_ee, l_priv;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 0; wait_n = 0;
            e_done = 0; e_exc = 0; e_code = 0; e_syn = 0; e_data = 0;
            e_rdwe = 0; e_rdd = 0; e_cwe = 0; e_carry = 0; e_serr = 0;
        end else begin
            e_done = 0; e_exc = 0; e_rdwe = 0; e_cwe = 0;
            if (busy == 0) begin
                if (req) begin
                    busy   = 1;
                    wait_n = AREA_OPT;
                    lk     = int'(idx % 16);
                    if (lk >= NUM_LINKS) lk = 0;
                    l_nb   = nb;
                    l_ctrl = ctrl;
                    l_ee   = ee && (EXC_EN != 0);
                    l_priv = um;
                end
            end else if (wait_n > 0) begin
                wait_n = wait_n - 1;
            end else if (l_priv) begin
                e_exc = 1; e_code = 5'd7; busy = 0;
            end else if (tvalid[lk]) begin
                if (tlast[lk] != l_ctrl) begin
                    e_serr = 1;
                end
                if (tlast[lk] != l_ctrl && l_ee) begin
                    e_exc = 1; e_code = 5'd0; e_syn = 4'(lk);
                    e_data = tdata[lk*DATA_W +: DATA_W];
                end else begin
                    e_done = 1; e_rdwe = 1;
                    e_rdd = tdata[lk*DATA_W +: DATA_W];
                end
                if (l_nb) begin
                    e_cwe = 1; e_carry = 0;
                end
                busy = 0;
            end else if (l_nb) begin
                e_done = 1; e_cwe = 1; e_carry = 1; busy = 0;
            end
        end
    end

    always @* begin
        e_stall  = (busy != 0);
        e_tready = '0;
        if (busy != 0 && wait_n == 0 && !l_priv && tvalid[lk]) e_tready[lk] = 1'b1;
    end
endmodule

module tb_strm_link_rd;
    localparam int NL = 5;
    localparam int DW = 32;

    logic clk = 0;
    logic rst_n = 0;
    logic req = 0;
    logic [31:0] idx = 0;
    logic nb = 0, ctrl = 0, ee = 0, um = 0;
    logic [NL-1:0] tvalid = 0, tlast = 0;
    logic [NL*DW-1:0] tdata = 0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    logic [NL-1:0] a_tr, b_tr, ma_tr, mb_tr;
    logic a_st, a_dn, a_we, a_cwe, a_cy, a_se, a_ex;
    logic b_st, b_dn, b_we, b_cwe, b_cy, b_se, b_ex;
    logic [DW-1:0] a_rd, a_ed, b_rd, b_ed;
    logic [4:0] a_ec, b_ec;
    logic [3:0] a_sy, b_sy;
    logic ma_dn, ma_ex, ma_we, ma_cwe, ma_cy, ma_se, ma_st;
    logic mb_dn, mb_ex, mb_we, mb_cwe, mb_cy, mb_se, mb_st;
    logic [4:0] ma_ec, mb_ec;
    logic [3:0] ma_sy, mb_sy;
    logic [DW-1:0] ma_ed, ma_rd, mb_ed, mb_rd;

    strm_link_rd #(.NUM_LINKS(NL), .DATA_W(DW), .IDX_W(32), .EXC_EN(1'b1),
                   .ALLOW_USER(1'b0), .AREA_OPT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .idx_i(idx), .nonblk_i(nb),
        .ctrl_i(ctrl), .exc_en_i(ee), .user_mode_i(um), .s_tvalid_i(tvalid),
        .s_tlast_i(tlast), .s_tdata_i(tdata), .s_tready_o(a_tr), .stall_o(a_st),
        .done_o(a_dn), .rd_we_o(a_we), .rd_data_o(a_rd), .carry_we_o(a_cwe),
        .carry_o(a_cy), .serr_o(a_se), .exc_o(a_ex), .exc_code_o(a_ec),
        .exc_syn_o(a_sy), .exc_data_o(a_ed));

    strm_link_rd #(.NUM_LINKS(NL), .DATA_W(DW), .IDX_W(32), .EXC_EN(1'b0),
                   .ALLOW_USER(1'b0), .AREA_OPT(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .req_i(req), .idx_i(idx), .nonblk_i(nb),
        .ctrl_i(ctrl), .exc_en_i(ee), .user_mode_i(um), .s_tvalid_i(tvalid),
        .s_tlast_i(tlast), .s_tdata_i(tdata), .s_tready_o(b_tr), .stall_o(b_st),
        .done_o(b_dn), .rd_we_o(b_we), .rd_data_o(b_rd), .carry_we_o(b_cwe),
        .carry_o(b_cy), .serr_o(b_se), .exc_o(b_ex), .exc_code_o(b_ec),
        .exc_syn_o(b_sy), .exc_data_o(b_ed));

    tb_rd_model #(.NUM_LINKS(NL), .DATA_W(DW), .EXC_EN(1), .AREA_OPT(0)) mdl_a (
        .clk(clk), .rst_n(rst_n), .req(req), .idx(idx), .nb(nb), .ctrl(ctrl),
        .ee(ee), .um(um), .tvalid(tvalid), .tlast(tlast), .tdata(tdata),
        .e_done(ma_dn), .e_exc(ma_ex), .e_code(ma_ec), .e_syn(ma_sy), .e_data(ma_ed),
        .e_rdwe(ma_we), .e_rdd(ma_rd), .e_cwe(ma_cwe), .e_carry(ma_cy),
        .e_serr(ma_se), .e_stall(ma_st), .e_tready(ma_tr));

    tb_rd_model #(.NUM_LINKS(NL), .DATA_W(DW), .EXC_EN(0), .AREA_OPT(1)) mdl_b (
        .clk(clk), .rst_n(rst_n), .req(req), .idx(idx), .nb(nb), .ctrl(ctrl),
        .ee(ee), .um(um), .tvalid(tvalid), .tlast(tlast), .tdata(tdata),
        .e_done(mb_dn), .e_exc(mb_ex), .e_code(mb_ec), .e_syn(mb_sy), .e_data(mb_ed),
        .e_rdwe(mb_we), .e_rdd(mb_rd), .e_cwe(mb_cwe), .e_carry(mb_cy),
        .e_serr(mb_se), .e_stall(mb_st), .e_tready(mb_tr));

    task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    bit cmp_on = 0;

    // per-cycle comparison against the reference models
    always @(negedge clk) begin
        if (cmp_on) begin
            cmp("R3", "a tready", 64'(a_tr), 64'(ma_tr));
            cmp("R4", "a stall", 64'(a_st), 64'(ma_st));
            cmp("R10", "a done", 64'(a_dn), 64'(ma_dn));
            cmp("R10", "a exc", 64'(a_ex), 64'(ma_ex));
            cmp("R2", "a rd_we", 64'(a_we), 64'(ma_we));
            cmp("R5", "a carry_we", 64'(a_cwe), 64'(ma_cwe));
            cmp("R6", "a serr", 64'(a_se), 64'(ma_se));
            if (ma_we) cmp("R2", "a rd_data", 64'(a_rd), 64'(ma_rd));
            if (ma_cwe) cmp("R5", "a carry", 64'(a_cy), 64'(ma_cy));
            if (ma_ex) cmp("R8", "a exc_code", 64'(a_ec), 64'(ma_ec));
            if (ma_ex && ma_ec == 5'd0) begin
                cmp("R7", "a exc_syn", 64'(a_sy), 64'(ma_sy));
                cmp("R7", "a exc_data", 64'(a_ed), 64'(ma_ed));
            end
            cmp("R3", "b tready", 64'(b_tr), 64'(mb_tr));
            cmp("R4", "b stall", 64'(b_st), 64'(mb_st));
            cmp("R10", "b done", 64'(b_dn), 64'(mb_dn));
            cmp("R7", "b exc", 64'(b_ex), 64'(mb_ex));
            cmp("R2", "b rd_we", 64'(b_we), 64'(mb_we));
            cmp("R5", "b carry_we", 64'(b_cwe), 64'(mb_cwe));
            cmp("R6", "b serr", 64'(b_se), 64'(mb_se));
            if (mb_we) cmp("R2", "b rd_data", 64'(b_rd), 64'(mb_rd));
            if (mb_cwe) cmp("R5", "b carry", 64'(b_cy), 64'(mb_cy));
            if (mb_ex) cmp("R8", "b exc_code", 64'(b_ec), 64'(mb_ec));
        end
    end

    task automatic set_link(int i, bit v, bit l, logic [DW-1:0] d);
        tvalid[i] = v;
        tlast[i] = l;
        tdata[i*DW +: DW] = d;
    endtask

    task automatic issue(logic [31:0] ix, bit f_nb, bit f_ctrl, bit f_ee, bit f_um);
        @(negedge clk); #1;
        req = 1; idx = ix; nb = f_nb; ctrl = f_ctrl; ee = f_ee; um = f_um;
        @(negedge clk); #1;
        req = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (!ma_st && !mb_st) break;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // reset state
        cmp("R4", "reset stall", 64'(a_st), 64'd0);
        cmp("R10", "reset done", 64'(a_dn), 64'd0);
        cmp("R6", "reset serr", 64'(a_se), 64'd0);
        cmp("R3", "reset tready", 64'(a_tr), 64'd0);
        cmp_on = 1;

        for (int i = 0; i < NL; i++) set_link(i, 0, 0, 32'hA000_0000 + 32'(i));

        // R2: plain blocking read from link 2
        set_link(2, 1, 0, 32'h1234_5678);
        issue(32'h0000_0002, 0, 0, 0, 0);
        wait_idle();

        // R1: index 7 is out of range and falls back to link 0
        set_link(0, 1, 1, 32'h0BAD_0000);
        issue(32'hFFFF_FFF7, 0, 1, 0, 0);
        wait_idle();
        cmp("R1", "clamped link data", 64'(a_rd), 64'h0BAD_0000);

        // R1: upper index bits ignored, 0x...34 selects link 4
        set_link(4, 1, 0, 32'h4444_0004);
        issue(32'h1234_5634, 0, 0, 0, 0);
        wait_idle();
        cmp("R1", "low nibble link data", 64'(a_rd), 64'h4444_0004);

        // R5: non-blocking on an empty link 3 sets carry
        set_link(3, 0, 0, 32'h3);
        issue(32'd3, 1, 0, 0, 0);
        wait_idle();
        cmp("R5", "empty carry", 64'(a_cy), 64'd1);

        // R5: non-blocking on a full link clears carry
        set_link(3, 1, 0, 32'h3333_0003);
        issue(32'd3, 1, 0, 0, 0);
        wait_idle();
        cmp("R5", "full carry", 64'(a_cy), 64'd0);

        // R4 and R10: blocking wait on link 1; requests during the wait are ignored
        set_link(1, 0, 0, 32'h1111_0001);
        issue(32'd1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        cmp("R4", "still stalled", 64'(a_st), 64'd1);
        issue(32'd2, 1, 0, 0, 0);
        repeat (2) @(negedge clk);
        #1 set_link(1, 1, 0, 32'h1111_0001);
        wait_idle();
        cmp("R10", "ignored req kept link 1", 64'(a_rd), 64'h1111_0001);

        // R6: mismatch without trap sets the sticky bit and completes
        set_link(2, 1, 1, 32'h2222_0002);
        issue(32'd2, 0, 0, 0, 0);
        wait_idle();
        cmp("R6", "serr set", 64'(a_se), 64'd1);

        // R7: mismatch with trap; dut_b has EXC_EN=0 and completes normally
        set_link(4, 1, 0, 32'hCAFE_0004);
        issue(32'd4, 0, 1, 1, 0);
        wait_idle();
        cmp("R7", "exc syndrome", 64'(a_sy), 64'd4);
        cmp("R7", "exc data", 64'(a_ed), 64'hCAFE_0004);
        cmp("R7", "no-trap build read", 64'(b_rd), 64'hCAFE_0004);
        cmp("R6", "serr still set", 64'(a_se), 64'd1);

        // R8: user-mode access refused
        issue(32'd2, 1, 0, 0, 1);
        wait_idle();
        cmp("R8", "priv code", 64'(a_ec), 64'd7);

        // R9: latency with data already present
        begin
            int la = 0;
            int lb = 0;
            set_link(0, 1, 0, 32'h0000_5A5A);
            @(negedge clk); #1;
            req = 1; idx = 0; nb = 0; ctrl = 0; ee = 0; um = 0;
            for (int n = 1; n <= 8; n++) begin
                @(negedge clk);
                if (la == 0 && (a_dn || a_ex)) la = n;
                if (lb == 0 && (b_dn || b_ex)) lb = n;
                #1 req = 0;
            end
            cmp("R9", "latency fast", 64'(la), 64'd2);
            cmp("R9", "latency area", 64'(lb), 64'd3);
        end
        wait_idle();

        cmp_on = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule